// File: doc/BRIEF.md
# Pixel Hit Readout Formatter

This block turns the triggered hits of one pixel readout chip into a stream of fixed-format symbols, one symbol per clock. A trigger pulse starts a readout frame. The frame opens with a fixed header word and then a running readout number. After that come the hits that the hit FIFO presents one after another. Each hit takes six symbol periods. The first five carry the pixel address and the sixth carries the digitized pulse height.

Each hit carries a double-column index (0 to 25), a pixel index within that double column (0 to 159) and an 8-bit pulse height. The 5-bit column index and the 8-bit pixel index are joined, column first, into a 13-bit address. That address is padded to 15 bits and sent most significant part first, three bits per symbol. A frame ends at the first slot where a hit could be accepted but the FIFO has none waiting. The last symbol of the frame is marked with an end strobe, and the first symbol is marked with a start strobe.

Top module: `pxl_readout_fmt`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `sym_valid_o`, `sof_o`, `eof_o` and `hit_ready_o` are all 0 and `sym_o` is 0. The first frame after reset carries readout number 0.
- R2: A `trig_i` pulse sampled while the block is idle produces the header symbol 8'hE3 on the next cycle, with `sof_o` = 1 and `sym_valid_o` = 1. The header value is larger than 7, so no address symbol can equal it.
- R3: The symbol right after the header is the 8-bit readout number. This number goes up by one after every completed frame and wraps from 255 to 0.
- R4: Each hit is sent as six consecutive symbols, in this order:
  - first, the bits of {2'b00, dcol[4:0], pix[7:0]} three at a time, most significant first, each placed in `sym_o[2:0]` with `sym_o[7:3]` = 0;
  - then the pulse height as the full 8 bits.
- R5: `hit_ready_o` is 1 only in the readout-number slot and in the pulse-height slot of each hit. A hit is taken when `hit_valid_i` is 1 in such a slot, which makes consecutive hits exactly six cycles apart. Every hit offered during a frame is sent exactly once.
- R6: `eof_o` is 1 on the last symbol of a frame. That is the readout-number slot when no hit is waiting there, so an empty frame is exactly two symbols long. Otherwise it is the pulse-height slot of the last hit. In the cycle after `eof_o`, `sym_valid_o` is 0.
- R7: A `trig_i` pulse while a frame is in progress is ignored. It does not lengthen the frame, it does not start a new header, and the block stays idle after the frame ends.
- R8: `sym_valid_o` stays 1 without a gap from the header to the end-of-frame symbol, and is 0 while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Start-of-readout pulse |
| hit_valid_i | input | 1 | Hit FIFO has a hit waiting |
| hit_ready_o | output | 1 | Hit is accepted this cycle if valid |
| hit_dcol_i | input | 5 | Double-column index of the waiting hit |
| hit_pix_i | input | 8 | Pixel index within the double column |
| hit_ph_i | input | 8 | Digitized pulse height |
| sym_o | output | 8 | Output symbol |
| sym_valid_o | output | 1 | Symbol is part of a frame |
| sof_o | output | 1 | First symbol of a frame |
| eof_o | output | 1 | Last symbol of a frame |

## Verification
The bench targets these corner cases:
- Empty frames: a design that waited for a hit, or sent an address slot anyway, would produce a frame longer than two symbols or no end strobe on the readout number.
- Extreme addresses (column 25 with pixel 159, and all zeros) and back-to-back hits: a wrong padding or bit order would shift bits between symbols, and taking a hit in the wrong slot would duplicate or drop hits.
- The readout number across its wrap from 255 to 0: an error here would make the number stall or overflow.
- A trigger pulse in the middle of a frame: a design that did not ignore it would restart the header or add a second frame.

// File: rtl/pxf_pkg.sv
package pxf_pkg;

  typedef enum logic [2:0] {
    SL_IDLE = 3'd0,
    SL_HDR  = 3'd1,
    SL_CNT  = 3'd2,
    SL_ADDR = 3'd3,
    SL_PH   = 3'd4
  } slot_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/pxf_rst_sync.sv
module pxf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;

endmodule

// File: rtl/pxf_seq.sv
module pxf_seq
  import pxf_pkg::*;
#(
  parameter int NSYM  = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n_s,
  input  logic             trig_i,
  input  logic             hit_valid_i,
  output slot_e            slot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             take_o,
  output logic             open_o,
  output logic             done_o
);

  slot_e            slot_q, slot_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_last;

  assign idx_last = (idx_q == IDX_W'(NSYM - 1));
  assign open_o   = (slot_q == SL_CNT) || (slot_q == SL_PH);
  assign take_o   = open_o && hit_valid_i;
  assign done_o   = open_o && !hit_valid_i;

  always_comb begin
    slot_d = slot_q;
    idx_d  = idx_q;
    unique case (slot_q)
      SL_IDLE: if (trig_i) slot_d = SL_HDR;
      SL_HDR:  slot_d = SL_CNT;
      SL_CNT, SL_PH: begin
        if (hit_valid_i) begin
          slot_d = SL_ADDR;
          idx_d  = '0;
        end else begin
          slot_d = SL_IDLE;
        end
      end
      SL_ADDR: begin
        if (idx_last) slot_d = SL_PH;
        else          idx_d  = idx_q + 1'b1;
      end
      default: slot_d = SL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      slot_q <= SL_IDLE;
      idx_q  <= '0;
    end else begin
      slot_q <= slot_d;
      idx_q  <= idx_d;
    end
  end

  assign slot_o = slot_q;
  assign idx_o  = idx_q;

  // R5: an accepted hit always starts at the first address symbol
  p_take_starts_addr_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    take_o |=> (slot_q == SL_ADDR) && (idx_q == '0));

  // R6: frame end returns the sequencer to idle
  p_done_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> (slot_q == SL_IDLE));

  // R7: a trigger during a frame never restarts the header
  p_busy_trig_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (slot_q != SL_IDLE) && trig_i |=> (slot_q != SL_HDR));

endmodule

// File: rtl/pxf_addr_enc.sv
module pxf_addr_enc #(
  parameter int DCOL_W   = 5,
  parameter int PIX_W    = 8,
  parameter int SYM_BITS = 3,
  parameter int NSYM     = 5,
  parameter int IDX_W    = 3
) (
  input  logic [DCOL_W-1:0]   dcol_i,
  input  logic [PIX_W-1:0]    pix_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [SYM_BITS-1:0] part_o
);

  localparam int ADDR_W = DCOL_W + PIX_W;
  localparam int PAD_W  = NSYM * SYM_BITS - ADDR_W;

  logic [NSYM*SYM_BITS-1:0] padded;
  logic [SYM_BITS-1:0]      parts [NSYM];

  generate
    if (PAD_W > 0) begin : g_pad
      assign padded = {{PAD_W{1'b0}}, dcol_i, pix_i};
    end else begin : g_nopad
      assign padded = {dcol_i, pix_i};
    end
  endgenerate

  for (genvar k = 0; k < NSYM; k++) begin : g_part
    assign parts[k] = padded[(NSYM-1-k)*SYM_BITS +: SYM_BITS];
  end

  always_comb begin
    part_o = '0;
    for (int k = 0; k < NSYM; k++) begin
      if (idx_i == IDX_W'(k)) part_o = parts[k];
    end
  end

endmodule

// File: rtl/pxf_rdo_ctr.sv
module pxf_rdo_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n_s,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3: the readout number moves by exactly one per completed frame
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    step_i |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !step_i |=> $stable(cnt_q));

endmodule

// File: rtl/pxl_readout_fmt.sv
module pxl_readout_fmt
  import pxf_pkg::*;
#(
  parameter int         DCOL_W   = 5,
  parameter int         PIX_W    = 8,
  parameter int         PH_W     = 8,
  parameter int         SYM_BITS = 3,
  parameter int         SYM_W    = 8,
  parameter int         CNT_W    = 8,
  parameter logic [7:0] HDR_WORD = 8'hE3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              hit_valid_i,
  output logic              hit_ready_o,
  input  logic [DCOL_W-1:0] hit_dcol_i,
  input  logic [PIX_W-1:0]  hit_pix_i,
  input  logic [PH_W-1:0]   hit_ph_i,
  output logic [SYM_W-1:0]  sym_o,
  output logic              sym_valid_o,
  output logic              sof_o,
  output logic              eof_o
);

  localparam int ADDR_W = DCOL_W + PIX_W;
  localparam int NSYM   = ceil_div(ADDR_W, SYM_BITS);
  localparam int IDX_W  = (NSYM > 1) ? $clog2(NSYM) : 1;

  logic              rst_n_s;
  slot_e             slot;
  logic [IDX_W-1:0]  idx;
  logic              take, open_slot, done;
  logic [CNT_W-1:0]  rdo_cnt;
  logic [SYM_BITS-1:0] part;

  logic [DCOL_W-1:0] dcol_q;
  logic [PIX_W-1:0]  pix_q;
  logic [PH_W-1:0]   ph_q;

  pxf_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  pxf_seq #(.NSYM(NSYM), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n_s     (rst_n_s),
    .trig_i      (trig_i),
    .hit_valid_i (hit_valid_i),
    .slot_o      (slot),
    .idx_o       (idx),
    .take_o      (take),
    .open_o      (open_slot),
    .done_o      (done)
  );

  pxf_rdo_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n_s (rst_n_s),
    .step_i  (done),
    .cnt_o   (rdo_cnt)
  );

  pxf_addr_enc #(
    .DCOL_W(DCOL_W), .PIX_W(PIX_W), .SYM_BITS(SYM_BITS),
    .NSYM(NSYM), .IDX_W(IDX_W)
  ) u_enc (
    .dcol_i (dcol_q),
    .pix_i  (pix_q),
    .idx_i  (idx),
    .part_o (part)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dcol_q <= '0;
      pix_q  <= '0;
      ph_q   <= '0;
    end else if (take) begin
      dcol_q <= hit_dcol_i;
      pix_q  <= hit_pix_i;
      ph_q   <= hit_ph_i;
    end
  end

  always_comb begin
    sym_o       = '0;
    sym_valid_o = 1'b1;
    unique case (slot)
      SL_HDR:  sym_o = SYM_W'(HDR_WORD);
      SL_CNT:  sym_o = SYM_W'(rdo_cnt);
      SL_ADDR: sym_o = SYM_W'(part);
      SL_PH:   sym_o = SYM_W'(ph_q);
      default: sym_valid_o = 1'b0;
    endcase
  end

  assign sof_o       = (slot == SL_HDR);
  assign eof_o       = done;
  assign hit_ready_o = open_slot;

  // R2: every frame opens with the start strobe
  p_sof_first_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sym_valid_o ##1 sym_valid_o |-> sof_o);

  // R6: nothing is valid right after the end strobe
  p_eof_gap_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    eof_o |=> !sym_valid_o);

  // R8: no gap inside a frame
  p_no_gap_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    sym_valid_o && !eof_o |=> sym_valid_o);

  // R4: address symbols stay within the symbol bit range
  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (slot == SL_ADDR) |-> (sym_o < SYM_W'(2 ** SYM_BITS)));

endmodule

// File: tb/tb_pxl_readout_fmt.sv
module tb_pxl_readout_fmt;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig_i;
  logic       hit_valid_i;
  logic       hit_ready_o;
  logic [4:0] hit_dcol_i;
  logic [7:0] hit_pix_i;
  logic [7:0] hit_ph_i;
  logic [7:0] sym_o;
  logic       sym_valid_o, sof_o, eof_o;

  int total = 0;
  int bad   = 0;
  int exp_cnt = 0;

  logic [4:0] f_d [64];
  logic [7:0] f_p [64];
  logic [7:0] f_h [64];
  int fifo_n = 0;
  int fifo_ptr = 0;

  always #10 clk = ~clk;

  pxl_readout_fmt dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .hit_valid_i(hit_valid_i), .hit_ready_o(hit_ready_o),
    .hit_dcol_i(hit_dcol_i), .hit_pix_i(hit_pix_i), .hit_ph_i(hit_ph_i),
    .sym_o(sym_o), .sym_valid_o(sym_valid_o), .sof_o(sof_o), .eof_o(eof_o)
  );

  assign hit_valid_i = (fifo_ptr < fifo_n);
  assign hit_dcol_i  = f_d[fifo_ptr % 64];
  assign hit_pix_i   = f_p[fifo_ptr % 64];
  assign hit_ph_i    = f_h[fifo_ptr % 64];

  always @(posedge clk) begin
    if (hit_valid_i && hit_ready_o) fifo_ptr <= fifo_ptr + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input int d, input int p, input int h);
    f_d[fifo_n] = 5'(d);
    f_p[fifo_n] = 8'(p);
    f_h[fifo_n] = 8'(h);
    fifo_n++;
  endtask

  // runs one frame; hits [first, fifo_n) are expected in it
  task automatic run_frame(input bit mid_trig, input bit quiet);
    int first = fifo_ptr;
    int nh = fifo_n - first;
    int len = 2 + 6 * nh;
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    for (int k = 0; k < len; k++) begin
      logic [7:0] es;
      bit er, esof, eeof;
      string rq;
      #1;
      esof = (k == 0);
      eeof = (k == len - 1);
      er = 1'b0;
      if (k == 0) begin es = 8'hE3; rq = "R2"; end
      else if (k == 1) begin es = 8'(exp_cnt); er = 1'b1; rq = "R3"; end
      else begin
        int h = first + (k - 2) / 6;
        int s = (k - 2) % 6;
        logic [14:0] a = {2'b00, f_d[h], f_p[h]};
        if (s < 5) begin es = {5'b0, 3'(a >> (3 * (4 - s)))}; rq = "R4"; end
        else begin es = f_h[h]; er = 1'b1; rq = "R4"; end
      end
      if (!quiet || k == 1) begin
        chk(sym_valid_o && sym_o == es, rq, {sym_valid_o, sym_o}, {1'b1, es});
        chk(sof_o == esof && eof_o == eeof, eeof ? "R6" : "R8",
            {sof_o, eof_o}, {esof, eeof});
        chk(hit_ready_o == er, "R5", hit_ready_o, er);
      end
      trig_i = (mid_trig && k == 2);
      @(negedge clk);
    end
    trig_i = 1'b0;
    #1;
    chk(!sym_valid_o && !sof_o, "R6", {sym_valid_o, sof_o}, 0);
    @(negedge clk); #1;
    chk(!sym_valid_o && !sof_o, "R7", {sym_valid_o, sof_o}, 0);
    if (!quiet) chk(fifo_ptr == fifo_n, "R5", fifo_ptr, fifo_n);
    exp_cnt = (exp_cnt + 1) % 256;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; trig_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!sym_valid_o && !sof_o && !eof_o && !hit_ready_o && sym_o == 0, "R1",
        {sym_valid_o, sof_o, eof_o, hit_ready_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!sym_valid_o && !hit_ready_o && sym_o == 0, "R1", {sym_valid_o, hit_ready_o}, 0);
  endtask

  task automatic t_empty();
    run_frame(1'b0, 1'b0);
  endtask

  task automatic t_single();
    push(25, 159, 8'hA7);
    run_frame(1'b0, 1'b0);
    push(0, 0, 8'h00);
    run_frame(1'b0, 1'b0);
  endtask

  task automatic t_burst();
    push(3, 77, 8'h5C);
    push(17, 1, 8'hFF);
    push(10, 128, 8'h01);
    push(24, 85, 8'h3E);
    run_frame(1'b0, 1'b0);
  endtask

  task automatic t_busy_trig();
    push(12, 42, 8'h99);
    push(1, 158, 8'h66);
    run_frame(1'b1, 1'b0);
    repeat (4) begin
      @(negedge clk); #1;
      chk(!sym_valid_o, "R7", sym_valid_o, 0);
    end
  endtask

  task automatic t_wrap();
    while (exp_cnt != 254) run_frame(1'b0, 1'b1);
    run_frame(1'b0, 1'b0);
    run_frame(1'b0, 1'b0);
    run_frame(1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_empty();
    t_single();
    t_burst();
    t_busy_trig();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule